// File: doc/BRIEF.md
# Carry/Borrow Loop Filter for an All-Digital PLL

This block is the loop filter between the phase detector and the digitally controlled oscillator of an all-digital phase-locked loop. It takes no parallel error value. Instead, a single direction bit, usually the output of an XOR phase detector, chooses which of two modulus-K counters advances on each clock. The filter clock runs at M times the loop's centre frequency, and K and M are powers of two.

Each time the up counter wraps, the block produces a one-clock `carry` pulse. Each time the down counter wraps, it produces a one-clock `borrow` pulse. The oscillator that follows uses these pulses to add or remove half-cycles. While the loop is locked, the detector's duty is about one half, so carries and borrows occur at the same average rate. When the input frequency rises, the duty shifts and carries outnumber borrows.

The two counters keep their contents while they are idle, so short excursions of the direction bit add up over time. When the direction bit is held, successive pulses come exactly K clocks apart, which is K/(M·fo) in time. A choice of K = M/4 gives a filter that adds no phase jitter.

Top module: `kcf_top`

## Requirements
- R1: While `rst_n` is low, `carry` and `borrow` are both low. A clock edge with `rst_n` low sets both internal counts to 0.
- R2: When `dir_up` = 1, only the up counter advances by one per clock. The down counter keeps its value.
- R3: When `dir_up` = 0, only the down counter advances by one per clock. The up counter keeps its value.
- R4: `carry` is high in exactly those cycles where `rst_n` = 1, `dir_up` = 1 and the up count equals K-1. The up count then wraps to 0 at the next edge.
- R5: `borrow` is high in exactly those cycles where `rst_n` = 1, `dir_up` = 0 and the down count equals K-1. The down count then wraps to 0 at the next edge.
- R6: `carry` and `borrow` are never high in the same cycle, and neither output is high in two consecutive cycles.
- R7: With `dir_up` held at 1 (or at 0) from reset, the first pulse arrives in the K-th cycle, and after that a pulse arrives every K cycles.
- R8: With a direction pattern of 50% duty, the carry and borrow counts are equal. With a 75%-high pattern, carries outnumber borrows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Filter clock, M times the centre frequency |
| rst_n | input | 1 | Synchronous reset, active low |
| dir_up | input | 1 | Direction from the phase detector: 1 advances the up counter, 0 advances the down counter |
| carry | output | 1 | One-clock pulse on each wrap of the up counter |
| borrow | output | 1 | One-clock pulse on each wrap of the down counter |

## Verification
The embedded properties run on every cycle. They check that both outputs stay low in reset, that a pulse is never held for two cycles and that carry and borrow never coincide. They also check that an idle counter holds its value and that an enabled counter at K-1 wraps to zero. Only the bench scenarios can show the accumulated behaviour: the K-cycle spacing under a steady direction, counts kept across direction changes and a mid-run reset, and the carry/borrow balance that follows the detector's duty.

// File: rtl/kcf_pkg.sv
// Package: shared definitions for the carry/borrow loop filter.
// Assumes: counter widths are set by the LOG2_K parameter of the top.
package kcf_pkg;
    // Index of each counter within the filter's counter pair.
    localparam int unsigned IDX_UP   = 0;
    localparam int unsigned IDX_DOWN = 1;
    localparam int unsigned N_CNT    = 2;
endpackage

// File: rtl/kcf_modk_counter.sv
// Module: modulus-2**LOG2_K counter that advances only when enabled.
// It wraps from K-1 to 0 and flags the wrap cycle combinationally.
// Assumes: synchronous active-low reset; LOG2_K in 2..16.
module kcf_modk_counter #(
    parameter int unsigned LOG2_K = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic wrap
);
    localparam logic [LOG2_K-1:0] TOP = {LOG2_K{1'b1}};

    logic [LOG2_K-1:0] cnt_q;

    // Count state: cleared in reset, advanced by one when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)  cnt_q <= '0;
        else if (en) cnt_q <= cnt_q + 1'b1;
    end

    // Wrap flag: high in the cycle where the enabled count is at K-1.
    always_comb wrap = rst_n && en && (cnt_q == TOP);

    // R4/R5: an enabled count at K-1 must be zero after the edge.
    p_wrap_to_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cnt_q == TOP) |=> (cnt_q == '0));

    // R2/R3: an idle counter holds its value.
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && $past(rst_n)) |=> $stable(cnt_q));
endmodule

// File: rtl/kcf_top.sv
// Module: loop filter made of two modulus-K counters steered by a
// direction bit. The up counter emits carry pulses and the down counter
// emits borrow pulses.
// Assumes: K = 2**LOG2_K with LOG2_K in 2..16; synchronous active-low reset.
module kcf_top #(
    parameter int unsigned LOG2_K = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dir_up,
    output logic carry,
    output logic borrow
);
    import kcf_pkg::*;

    logic [N_CNT-1:0] en_v;
    logic [N_CNT-1:0] wrap_v;

    // Steering: the direction bit enables exactly one counter.
    always_comb begin
        en_v           = '0;
        en_v[IDX_UP]   = dir_up;
        en_v[IDX_DOWN] = !dir_up;
    end

    // The pair of identical counters.
    for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
        kcf_modk_counter #(.LOG2_K(LOG2_K)) cnt_i (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (en_v[g]),
            .wrap  (wrap_v[g])
        );
    end

    // Output mapping from counter wrap flags to the pulse outputs.
    always_comb begin
        carry  = wrap_v[IDX_UP];
        borrow = wrap_v[IDX_DOWN];
    end

    // R1: both outputs quiet while reset is asserted.
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |-> (!carry && !borrow));

    // R6: carry and borrow never coincide.
    p_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(carry && borrow));

    // R6: a carry pulse lasts one cycle.
    p_carry_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        carry |=> !carry);

    // R6: a borrow pulse lasts one cycle.
    p_borrow_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        borrow |=> !borrow);
endmodule

// File: tb/kcf_top_tb_top.sv
// Bench: behavioural model of the two counts, compared with the outputs
// on every clock.
module kcf_top_tb_top;
    localparam int unsigned LOG2_K = 4;
    localparam int K = 1 << LOG2_K;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dir_up = 1'b0;
    logic carry, borrow;

    int n_chk = 0;
    int n_bad = 0;
    int m_up = 0;
    int m_dn = 0;
    int n_car = 0;
    int n_bor = 0;

    always #2.5 clk = ~clk;

    kcf_top #(.LOG2_K(LOG2_K)) dut_i (
        .clk(clk), .rst_n(rst_n), .dir_up(dir_up),
        .carry(carry), .borrow(borrow)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Drive one cycle: set inputs after an edge, compare mid-cycle,
    // then advance the model for the coming edge.
    task automatic step(input logic r, input logic d, input string req);
        int ec, eb;
        @(posedge clk);
        #1;
        rst_n = r;
        dir_up = d;
        #1;
        ec = (r && d && m_up == K-1) ? 1 : 0;
        eb = (r && !d && m_dn == K-1) ? 1 : 0;
        check({req, " carry"}, int'(carry), ec);
        check({req, " borrow"}, int'(borrow), eb);
        n_car += int'(carry);
        n_bor += int'(borrow);
        if (!r) begin
            m_up = 0;
            m_dn = 0;
        end else if (d) m_up = (m_up + 1) % K;
        else            m_dn = (m_dn + 1) % K;
    endtask

    initial begin : watchdog
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : stim
        int first;
        // R1: reset state
        for (int i = 0; i < 4; i++) step(1'b0, i[0], "R1");
        // R7 and R4: steady up direction, first carry in the K-th cycle
        first = -1;
        for (int i = 0; i < 3*K; i++) begin
            step(1'b1, 1'b1, "R4");
            if (carry && first < 0) first = i;
        end
        check("R7 first carry cycle", first, K-1);
        check("R7 carry count", n_car, 3);
        // R5: steady down direction
        n_car = 0; n_bor = 0;
        for (int i = 0; i < 2*K; i++) step(1'b1, 1'b0, "R5");
        check("R5 borrow count", n_bor, 2);
        check("R3 no carry while down", n_car, 0);
        // R2/R3: partial counts kept across direction switches
        for (int i = 0; i < K/2; i++) step(1'b1, 1'b1, "R2");
        for (int i = 0; i < K/2 + 3; i++) step(1'b1, 1'b0, "R3");
        for (int i = 0; i < K; i++) step(1'b1, 1'b1, "R2");
        // R1: reset mid-run clears partial counts
        step(1'b0, 1'b1, "R1");
        step(1'b0, 1'b0, "R1");
        // R8: 50% duty pattern
        n_car = 0; n_bor = 0;
        for (int i = 0; i < 8*K; i++) step(1'b1, i[0], "R8");
        check("R8 balanced carries", n_car, 4);
        check("R8 balanced borrows", n_bor, 4);
        // R8: 75% high duty
        n_car = 0; n_bor = 0;
        for (int i = 0; i < 16*K; i++) step(1'b1, (i % 4) != 0, "R8");
        check("R8 more carries", (n_car > n_bor) ? 1 : 0, 1);
        // R6: random-ish pattern, model comparison covers exclusivity
        for (int i = 0; i < 40*K; i++) step(1'b1, ((i * 7 + i / 5) % 3) != 0, "R6");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule